// File: doc/BRIEF.md
# Strobed Control Register Bank

This block holds three 8-bit write-only control registers on a data bus that the host also uses for other work. A write follows a fixed order. The host drives the byte onto the bus, pulls the shared active-low output enable low, and pulses the active-low strobe of one register low and then high. The register captures the bus when its strobe rises, and only while the output enable is low. Afterwards the host returns the data lines high and releases the enable.

The three registers are system control, monitor routing and clock control. Their contents appear unchanged on outputs. The system and clock registers are also decoded into named fields: input mode, mute, codec power-down, a one-hot internal rate select, a sync flag and a one-hot external clock source. A one-cycle error pulse reports a write of a code that is unused or forbidden. The byte is stored even in that case.

All inputs are taken to be synchronous to `clk`. A strobe rising edge is found by comparing the strobe against its value one cycle earlier. The register updates on the clock edge at which the strobe is first seen high again.

Top module: `ext_reg_bank`

## Requirements
- R1: After reset, all three registers read 0x00. The rate select is therefore 6'b000001 (bit 0 set for code 0). `ext_sync`, `ext_src`, `input_mode`, `mute` and `bad_write` are 0, and `codec_pd` is 1.
- R2: A strobe `reg_strobe_n[i]` (0 = system, 1 = monitor, 2 = clock) that is low in one cycle and high in the next, with `bus_oe_n` low in that second cycle, loads `bus_data` into register i on that clock edge. No other register changes.
- R3: A strobe rising edge while `bus_oe_n` is high changes no register.
- R4: A register does not change while its strobe is held low. The value stored is the bus value present when the strobe rises, not the value present when it fell.
- R5: `rate_sel[k]` is 1 exactly when clock bit 3 is 0 and clock bits 2:0 equal k, for k in 0..5. Codes 6 and 7, or clock bit 3 set, give all zeros.
- R6: `ext_sync` equals clock bit 3. With bit 3 set, `ext_src` is decoded from clock bits {4,2:0}:
  - 0000 gives 3'b001 (S/PDIF);
  - 0010 gives 3'b010 (1x word clock);
  - 1010 gives 3'b100 (256x word clock);
  - any other combination gives 0.
- R7: `input_mode` equals system bits 5:4 (00 line, 01 mic, 11 mic with low-cut). `mute` equals system bit 2. `codec_pd` is the inverse of system bit 7.
- R8: `bad_write` is high for exactly the one cycle after a capture in either of these cases:
  - a clock write with bit 3 = 0 and bits 2:0 equal to 6 or 7;
  - a system write with bits 5:4 = 10.

  The byte is still stored.
- R9: Strobes of several registers that rise in the same cycle with the enable low load the same bus byte into each of those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Shared data bus |
| bus_oe_n | input | 1 | Active-low bus output enable |
| reg_strobe_n | input | 3 | Active-low strobes: 0 system, 1 monitor, 2 clock |
| sys_q | output | 8 | System control register |
| mon_q | output | 8 | Monitor routing register |
| clk_q | output | 8 | Clock control register |
| rate_sel | output | 6 | One-hot internal rate select |
| ext_sync | output | 1 | External sync selected |
| ext_src | output | 3 | One-hot external source: S/PDIF, 1x, 256x |
| input_mode | output | 2 | Input mode field |
| mute | output | 1 | Hardware mute |
| codec_pd | output | 1 | Codec held powered down |
| bad_write | output | 1 | One-cycle pulse on a bad code write |

## Verification
Every register is visible on a port, so a wrong capture shows on the register output one cycle after the strobe edge. Each decoded field follows in the same cycle. Missing or mistimed edge detection shows up in two ways. It can be a capture while the strobe is still low, which is visible as the falling-edge byte rather than the rising-edge byte. It can also be a change while the enable is high. The bench puts a port read between each of these events. An error pulse that is missed or stuck is seen one cycle after the capture and again one cycle later.

// File: rtl/ext_reg_pkg.sv
package ext_reg_pkg;
  localparam int REG_COUNT = 3;
  localparam int IDX_SYS   = 0;
  localparam int IDX_MON   = 1;
  localparam int IDX_CLK   = 2;
  localparam int RATE_CNT  = 6;
  localparam int SRC_CNT   = 3;

  // internal rate decode: one-hot on codes 0..RATE_CNT-1, silent otherwise
  function automatic logic [RATE_CNT-1:0] rate_decode(input logic sync_ext,
                                                      input logic [2:0] code);
    logic [RATE_CNT-1:0] oh;
    oh = '0;
    if (!sync_ext && (int'(code) < RATE_CNT))
      oh[code] = 1'b1;
    return oh;
  endfunction

  // external source decode from clock bits {4,3,2:0}
  function automatic logic [SRC_CNT-1:0] src_decode(input logic [4:0] key);
    logic [SRC_CNT-1:0] s;
    s = '0;
    if (key[3]) begin
      case ({key[4], key[2:0]})
        4'b0000: s = 3'b001;
        4'b0010: s = 3'b010;
        4'b1010: s = 3'b100;
        default: s = '0;
      endcase
    end
    return s;
  endfunction

  function automatic logic bad_rate(input logic sync_ext, input logic [1:0] code_hi);
    return !sync_ext && (code_hi == 2'b11);
  endfunction

  function automatic logic bad_mode(input logic [1:0] mode);
    return mode == 2'b10;
  endfunction
endpackage

// File: rtl/strobe_capture.sv
module strobe_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] bus,
  output logic              hit,
  output logic [DATA_W-1:0] q
);
  logic strobe_prev;

  // rising strobe edge qualified by an enabled bus
  assign hit = strobe_n && !strobe_prev && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev <= 1'b1;
      q           <= '0;
    end else begin
      strobe_prev <= strobe_n;
      if (hit) q <= bus;
    end
  end
endmodule

// File: rtl/write_guard.sv
module write_guard (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_sys,
  input  logic       hit_clk,
  input  logic [5:4] bus_mode,
  input  logic [3:1] bus_rate,
  output logic       bad_write
);
  import ext_reg_pkg::*;
  logic bad_now;

  assign bad_now = (hit_sys && bad_mode(bus_mode)) ||
                   (hit_clk && bad_rate(bus_rate[3], bus_rate[2:1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_write <= 1'b0;
    else        bad_write <= bad_now;
  end
endmodule

// File: rtl/field_decode.sv
module field_decode
  import ext_reg_pkg::*;
(
  input  logic                sys_pwr,
  input  logic [1:0]          sys_mode,
  input  logic                sys_mute,
  input  logic [4:0]          clk_low,
  output logic [RATE_CNT-1:0] rate_sel,
  output logic                ext_sync,
  output logic [SRC_CNT-1:0]  ext_src,
  output logic [1:0]          input_mode,
  output logic                mute,
  output logic                codec_pd
);
  always_comb begin
    rate_sel   = rate_decode(clk_low[3], clk_low[2:0]);
    ext_src    = src_decode(clk_low);
    ext_sync   = clk_low[3];
    input_mode = sys_mode;
    mute       = sys_mute;
    codec_pd   = !sys_pwr;
  end
endmodule

// File: rtl/ext_reg_bank.sv
module ext_reg_bank
  import ext_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    bus_data,
  input  logic                 bus_oe_n,
  input  logic [REG_COUNT-1:0] reg_strobe_n,
  output logic [DATA_W-1:0]    sys_q,
  output logic [DATA_W-1:0]    mon_q,
  output logic [DATA_W-1:0]    clk_q,
  output logic [RATE_CNT-1:0]  rate_sel,
  output logic                 ext_sync,
  output logic [SRC_CNT-1:0]   ext_src,
  output logic [1:0]           input_mode,
  output logic                 mute,
  output logic                 codec_pd,
  output logic                 bad_write
);
  logic [REG_COUNT-1:0] cap_hit;
  logic [DATA_W-1:0]    reg_q [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    strobe_capture #(.DATA_W(DATA_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (reg_strobe_n[i]),
      .oe_n     (bus_oe_n),
      .bus      (bus_data),
      .hit      (cap_hit[i]),
      .q        (reg_q[i])
    );
  end

  assign sys_q = reg_q[IDX_SYS];
  assign mon_q = reg_q[IDX_MON];
  assign clk_q = reg_q[IDX_CLK];

  write_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_sys   (cap_hit[IDX_SYS]),
    .hit_clk   (cap_hit[IDX_CLK]),
    .bus_mode  (bus_data[5:4]),
    .bus_rate  (bus_data[3:1]),
    .bad_write (bad_write)
  );

  field_decode u_dec (
    .sys_pwr    (sys_q[7]),
    .sys_mode   (sys_q[5:4]),
    .sys_mute   (sys_q[2]),
    .clk_low    (clk_q[4:0]),
    .rate_sel   (rate_sel),
    .ext_sync   (ext_sync),
    .ext_src    (ext_src),
    .input_mode (input_mode),
    .mute       (mute),
    .codec_pd   (codec_pd)
  );
endmodule

// File: rtl/ext_reg_bank_chk.sv
module ext_reg_bank_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_oe_n,
  input logic [2:0]        reg_strobe_n,
  input logic [2:0]        cap_hit,
  input logic [DATA_W-1:0] sys_q,
  input logic [DATA_W-1:0] mon_q,
  input logic [DATA_W-1:0] clk_q,
  input logic [5:0]        rate_sel,
  input logic              ext_sync,
  input logic [2:0]        ext_src,
  input logic              bad_write
);
  AST_OE_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_n |=> ($stable(sys_q) && $stable(mon_q) && $stable(clk_q))); // R3
  AST_LOW_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_strobe_n[0] |=> $stable(sys_q)); // R4
  AST_CHANGE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_q) |-> ($past(reg_strobe_n[2]) && !$past(bus_oe_n))); // R2
  AST_HIT_LOADS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit[1] |=> (mon_q == $past(bus_data))); // R2
  AST_RATE_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rate_sel)); // R5
  AST_RATE_OFF_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync |-> (rate_sel == '0)); // R5
  AST_SRC_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_src)); // R6
  AST_SRC_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_src != '0) |-> ext_sync); // R6
  AST_BAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_write |-> ((!clk_q[3] && clk_q[2:1] == 2'b11) || sys_q[5:4] == 2'b10)); // R8
endmodule

bind ext_reg_bank ext_reg_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_data     (bus_data),
  .bus_oe_n     (bus_oe_n),
  .reg_strobe_n (reg_strobe_n),
  .cap_hit      (cap_hit),
  .sys_q        (sys_q),
  .mon_q        (mon_q),
  .clk_q        (clk_q),
  .rate_sel     (rate_sel),
  .ext_sync     (ext_sync),
  .ext_src      (ext_src),
  .bad_write    (bad_write)
);

// File: tb/tb_ext_reg_bank.sv
module tb_ext_reg_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_data = 8'hFF;
  logic       bus_oe_n = 1'b1;
  logic [2:0] reg_strobe_n = 3'b111;
  logic [7:0] sys_q, mon_q, clk_q;
  logic [5:0] rate_sel;
  logic       ext_sync;
  logic [2:0] ext_src;
  logic [1:0] input_mode;
  logic       mute, codec_pd, bad_write;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_oe_n(bus_oe_n),
    .reg_strobe_n(reg_strobe_n), .sys_q(sys_q), .mon_q(mon_q), .clk_q(clk_q),
    .rate_sel(rate_sel), .ext_sync(ext_sync), .ext_src(ext_src),
    .input_mode(input_mode), .mute(mute), .codec_pd(codec_pd),
    .bad_write(bad_write)
  );

  // row: sel[24:23] data[22:15] rate[14:9] sync[8] src[7:5] mode[4:3] mute[2] pd[1] bad[0]
  localparam int NV = 21;
  localparam logic [24:0] VEC [NV] = '{
    {2'd2, 8'h00, 6'b000001, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h01, 6'b000010, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h02, 6'b000100, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h03, 6'b001000, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h04, 6'b010000, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h05, 6'b100000, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h06, 6'b000000, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1, 1'b1},
    {2'd2, 8'h07, 6'b000000, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1, 1'b1},
    {2'd2, 8'h08, 6'b000000, 1'b1, 3'b001, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h0A, 6'b000000, 1'b1, 3'b010, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h1A, 6'b000000, 1'b1, 3'b100, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h0C, 6'b000000, 1'b1, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h1D, 6'b000000, 1'b1, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h0E, 6'b000000, 1'b1, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'hF3, 6'b001000, 1'b0, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd0, 8'h84, 6'b001000, 1'b0, 3'b000, 2'b00, 1'b1, 1'b0, 1'b0},
    {2'd0, 8'h10, 6'b001000, 1'b0, 3'b000, 2'b01, 1'b0, 1'b1, 1'b0},
    {2'd0, 8'hB0, 6'b001000, 1'b0, 3'b000, 2'b11, 1'b0, 1'b0, 1'b0},
    {2'd0, 8'h20, 6'b001000, 1'b0, 3'b000, 2'b10, 1'b0, 1'b1, 1'b1},
    {2'd0, 8'h94, 6'b001000, 1'b0, 3'b000, 2'b01, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'h5A, 6'b001000, 1'b0, 3'b000, 2'b01, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one full write; returns at the negedge after the capturing edge
  task automatic wr(input int idx, input logic [7:0] d, input bit oe);
    @(negedge clk) bus_data = d; bus_oe_n = !oe;
    @(negedge clk) reg_strobe_n[idx] = 1'b0;
    @(negedge clk) reg_strobe_n[idx] = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    bus_data = 8'hFF;
    bus_oe_n = 1'b1;
  endtask

  task automatic chk_reset_state();
    chk("R1", "sys_q", sys_q, 0);
    chk("R1", "mon_q", mon_q, 0);
    chk("R1", "clk_q", clk_q, 0);
    chk("R1", "rate_sel", rate_sel, 6'b000001);
    chk("R1", "ext_sync", ext_sync, 0);
    chk("R1", "ext_src", ext_src, 0);
    chk("R1", "input_mode", input_mode, 0);
    chk("R1", "mute", mute, 0);
    chk("R1", "codec_pd", codec_pd, 1);
    chk("R1", "bad_write", bad_write, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R5 rate, R6 external source, R7 system fields, R8 bad pulse, R2 capture
    for (int v = 0; v < NV; v++) begin
      logic [24:0] r;
      r = VEC[v];
      wr(int'(r[24:23]), r[22:15], 1'b1);
      case (r[24:23])
        2'd0: chk("R2", "sys_q", sys_q, r[22:15]);
        2'd1: chk("R2", "mon_q", mon_q, r[22:15]);
        default: chk("R2", "clk_q", clk_q, r[22:15]);
      endcase
      chk("R5", "rate_sel", rate_sel, r[14:9]);
      chk("R6", "ext_sync", ext_sync, r[8]);
      chk("R6", "ext_src", ext_src, r[7:5]);
      chk("R7", "input_mode", input_mode, r[4:3]);
      chk("R7", "mute", mute, r[2]);
      chk("R7", "codec_pd", codec_pd, r[1]);
      chk("R8", "bad_write", bad_write, r[0]);
      idle();
    end

    // R3: strobe edge with enable high is ignored
    wr(2, 8'h05, 1'b0);
    chk("R3", "clk_q", clk_q, 8'hF3);
    chk("R3", "rate_sel", rate_sel, 6'b001000);
    idle();

    // R2: only the strobed register changes
    wr(1, 8'h3C, 1'b1);
    chk("R2", "mon_q", mon_q, 8'h3C);
    chk("R2", "sys_q untouched", sys_q, 8'h94);
    chk("R2", "clk_q untouched", clk_q, 8'hF3);
    idle();

    // R4: value at rising edge is stored, nothing while strobe low
    @(negedge clk) bus_data = 8'h01; bus_oe_n = 1'b0;
    @(negedge clk) reg_strobe_n[2] = 1'b0;
    @(negedge clk) bus_data = 8'h04;
    @(negedge clk);
    chk("R4", "clk_q while strobe low", clk_q, 8'hF3);
    reg_strobe_n[2] = 1'b1;
    @(negedge clk);
    chk("R4", "clk_q at rise", clk_q, 8'h04);
    chk("R4", "rate_sel", rate_sel, 6'b010000);
    idle();

    // R8: pulse lasts one cycle, byte kept
    wr(2, 8'h07, 1'b1);
    chk("R8", "bad_write", bad_write, 1);
    idle();
    @(negedge clk);
    chk("R8", "bad_write after", bad_write, 0);
    chk("R8", "clk_q kept", clk_q, 8'h07);

    // R9: simultaneous strobes
    @(negedge clk) bus_data = 8'h55; bus_oe_n = 1'b0;
    @(negedge clk) reg_strobe_n = 3'b000;
    @(negedge clk) reg_strobe_n = 3'b111;
    @(negedge clk);
    chk("R9", "sys_q", sys_q, 8'h55);
    chk("R9", "mon_q", mon_q, 8'h55);
    chk("R9", "clk_q", clk_q, 8'h55);
    chk("R9", "rate_sel", rate_sel, 6'b100000);
    chk("R9", "input_mode", input_mode, 2'b01);
    idle();

    // R1: reset again mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule